// File: doc/BRIEF.md
# Decomposed-Reward SARSA Parameter Tuner

This block is a small learning agent that chooses the setting of one memory-controller parameter. Its value table holds a signed fixed-point estimate for every combination of state, candidate setting and reward component. The state is the setting that was in force during the epoch that just ended. At each decision epoch the agent takes in a vector of per-component rewards and one word of pseudo-random bits. It picks the next setting with an epsilon-greedy rule, where the greedy choice maximises the sum of the component estimates. It then applies an on-policy SARSA correction to every component of the previous state-action entry.

A chip instantiates one agent per tunable parameter, for example page policy with four options, scheduler with three, refresh slack with eight, or an active-transaction cap with eight powers of two. The agents run side by side and each gets its own random stream. The metric and reward computation that feeds the agent lives elsewhere, and so does the logic that applies the chosen code to the controller.

An epoch is served by a multi-cycle table walk. The agent raises `busy_o` for the whole walk and ignores further strobes until the walk ends. When it finishes, it pulses `done_o` for one cycle and presents the new code on `act_o` in that same cycle.

Top module: `sarsa_tune_agent`

## Requirements
- R1: After reset, `act_o` is 0, `busy_o` and `done_o` are low, and every table entry is zero.
- R2: On a greedy epoch, the next code is the legal option a' (0 to N_OPT-1) with the largest sum over components of Q(s, a', c), where s is the code that was applied. On a tie, the lowest-numbered option wins.
- R3: The agent explores when `rand_i[15:0]` is below the active epsilon threshold, an unsigned fraction of 65536. When it explores, the next code is `rand_i[31:16]` modulo N_OPT. Both fields are taken in the cycle the strobe is accepted.
- R4: The active threshold is EPS_HI while the number of epochs accepted before the current one is below WARMUP, and EPS_LO from then on. The default EPS_LO is 66, about 0.001.
- R5: For each component c, carried on `reward_i[16c+15:16c]`, the entry Q(s_old, a, c) becomes q + alpha*(err), with err = (r_c + gamma*Q(s, a', c)) - q. Here a is the code applied during the epoch and a' is the code just chosen. Values are signed Q8.8. Each product is floored after a shift of 8, and every intermediate result is saturated. The defaults are alpha = 26 (about 0.1) and gamma = 230 (about 0.9).
- R6: After an epoch, the state used by the next update is the code that was applied during this epoch, not any measured value.
- R7: Every stored value and every intermediate sum saturates to the range -32768..32767 instead of wrapping.
- R8: An accepted strobe raises `busy_o` for N_OPT*N_COMP + N_COMP + 2 cycles. A strobe that arrives while `busy_o` is high has no effect.
- R9: `act_o` changes only in the single cycle in which `done_o` is high, and `done_o` never stays high for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| epoch_i | input | 1 | Decision-epoch strobe |
| reward_i | input | N_COMP*16 | Per-component reward, signed Q8.8 each |
| rand_i | input | 32 | Pseudo-random word: low half for the epsilon test, high half for the random pick |
| act_o | output | ACT_W | Chosen parameter code |
| busy_o | output | 1 | Table walk in progress |
| done_o | output | 1 | One-cycle pulse when a new code is presented |

## Verification
The bench builds the agent with N_OPT = 3, N_COMP = 2 and WARMUP = 3, and keeps the default alpha, gamma, EPS_HI and EPS_LO. Three options make the random pick a true modulo that is not a power of two. A warmup of three epochs lets a single random value be tested on both sides of the epsilon switch within a few epochs. Two components keep a full-table reference model small enough to follow each greedy choice, including runs of maximal rewards that drive entries into saturation.

// File: rtl/sarsa_pkg.sv
package sarsa_pkg;

  typedef logic signed [15:0] qval_t;

  // sign-extend a Q8.8 value to a wide working width
  function automatic logic signed [39:0] ext40(input qval_t x);
    return {{24{x[15]}}, x};
  endfunction

  // clamp a wide value into Q8.8 range
  function automatic qval_t sat_q(input logic signed [39:0] v);
    if (v > 40'sd32767)       return 16'sh7fff;
    else if (v < -40'sd32768) return 16'sh8000;
    else                      return v[15:0];
  endfunction

  // Q8.8 product, floored, saturated
  function automatic qval_t fx_mul(input qval_t a, input qval_t b);
    logic signed [31:0] p;
    logic signed [39:0] w;
    p = a * b;
    w = {{8{p[31]}}, p};
    return sat_q(w >>> 8);
  endfunction

  // one SARSA correction of a single reward component
  function automatic qval_t sarsa_step(input qval_t q_old, input qval_t q_nxt,
                                       input qval_t rwd, input qval_t alpha,
                                       input qval_t gamma);
    qval_t tgt;
    qval_t err;
    tgt = sat_q(ext40(rwd) + ext40(fx_mul(gamma, q_nxt)));
    err = sat_q(ext40(tgt) - ext40(q_old));
    return sat_q(ext40(q_old) + ext40(fx_mul(alpha, err)));
  endfunction

endpackage

// File: rtl/sarsa_qstore.sv
module sarsa_qstore
  import sarsa_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int ADR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADR_W-1:0] rd_a_addr,
  output qval_t            rd_a_data,
  input  logic [ADR_W-1:0] rd_b_addr,
  output qval_t            rd_b_data,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  qval_t            wr_data
);

  qval_t mem [DEPTH];

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // R5: writes stay inside the table
  a_r5_wr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (32'(wr_addr) < DEPTH));

endmodule

// File: rtl/sarsa_explore.sv
module sarsa_explore #(
  parameter int          N_OPT  = 4,
  parameter int          ACT_W  = 2,
  parameter int          WARMUP = 14000,
  parameter logic [15:0] EPS_HI = 16'h8000,
  parameter logic [15:0] EPS_LO = 16'd66
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [31:0]      rand_i,
  output logic             explore_o,
  output logic [ACT_W-1:0] pick_o
);

  localparam int          CNT_W  = $clog2(WARMUP + 2);
  localparam logic [15:0] NOPT16 = 16'(N_OPT);

  logic [CNT_W-1:0] steps_q;
  logic             warm;
  logic [15:0]      eps_now;
  logic [15:0]      pick_mod;

  assign warm      = 32'(steps_q) < WARMUP;
  assign eps_now   = warm ? EPS_HI : EPS_LO;
  assign explore_o = rand_i[15:0] < eps_now;
  assign pick_mod  = rand_i[31:16] % NOPT16;
  assign pick_o    = pick_mod[ACT_W-1:0];

  always_ff @(posedge clk_i) begin
    if (!rst_ni)             steps_q <= '0;
    else if (step_i && warm) steps_q <= steps_q + 1'b1;
  end

  // R3: a random pick is always a legal option
  a_r3_pick_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(pick_o) < N_OPT);

endmodule

// File: rtl/sarsa_argmax.sv
module sarsa_argmax
  import sarsa_pkg::*;
#(
  parameter int N_OPT = 4,
  parameter int ACT_W = 2,
  parameter int SUM_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  qval_t            val_i,
  input  logic             close_i,
  input  logic [ACT_W-1:0] cand_i,
  output logic [ACT_W-1:0] best_o
);

  logic signed [SUM_W-1:0] acc_q;
  logic signed [SUM_W-1:0] best_sum_q;
  logic signed [SUM_W-1:0] total;
  logic                    have_q;
  logic                    better;

  assign total  = acc_q + {{(SUM_W-16){val_i[15]}}, val_i};
  assign better = !have_q || (total > best_sum_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || clr_i) begin
      acc_q      <= '0;
      best_sum_q <= '0;
      have_q     <= 1'b0;
      best_o     <= '0;
    end else if (add_i) begin
      if (close_i) begin
        acc_q  <= '0;
        have_q <= 1'b1;
        if (better) begin
          best_sum_q <= total;
          best_o     <= cand_i;
        end
      end else begin
        acc_q <= total;
      end
    end
  end

  // R2: winner is a legal option
  a_r2_best_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(best_o) < N_OPT);

endmodule

// File: rtl/sarsa_tune_agent.sv
module sarsa_tune_agent
  import sarsa_pkg::*;
#(
  parameter int          N_OPT  = 4,
  parameter int          N_COMP = 4,
  parameter int          WARMUP = 14000,
  parameter logic [15:0] EPS_HI = 16'h8000,
  parameter logic [15:0] EPS_LO = 16'd66,
  parameter logic [15:0] ALPHA  = 16'd26,
  parameter logic [15:0] GAMMA  = 16'd230,
  localparam int         ACT_W  = (N_OPT > 1) ? $clog2(N_OPT) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  epoch_i,
  input  logic [N_COMP*16-1:0]  reward_i,
  input  logic [31:0]           rand_i,
  output logic [ACT_W-1:0]      act_o,
  output logic                  busy_o,
  output logic                  done_o
);

  localparam int CMP_W = (N_COMP > 1) ? $clog2(N_COMP) : 1;
  localparam int DEPTH = N_OPT * N_OPT * N_COMP;
  localparam int ADR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SUM_W = 16 + CMP_W + 1;
  localparam int WC_W  = $clog2(N_COMP + 1) + 1;
  localparam logic [ACT_W-1:0] LAST_OPT  = ACT_W'(N_OPT - 1);
  localparam logic [CMP_W-1:0] LAST_COMP = CMP_W'(N_COMP - 1);

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_PICK, S_UPD, S_DONE} st_e;

  function automatic logic [ADR_W-1:0] addr_of(input logic [ACT_W-1:0] s,
                                               input logic [ACT_W-1:0] a,
                                               input logic [CMP_W-1:0] c);
    return ADR_W'((int'(s) * N_OPT + int'(a)) * N_COMP + int'(c));
  endfunction

  st_e              state_q;
  logic [ACT_W-1:0] s_old_q, s_new_q, a_next_q, scan_a_q, pick_q;
  logic [CMP_W-1:0] comp_q;
  logic             expl_q;
  qval_t            rwd_q [N_COMP];

  // named internal events
  logic             accept;
  logic             scan_add;
  logic             scan_close;
  logic             upd_wr;
  logic             expl_now;
  logic [ACT_W-1:0] pick_now;
  logic [ACT_W-1:0] best;
  logic [ADR_W-1:0] rd_a_addr, rd_b_addr;
  qval_t            rd_a_data, rd_b_data, wr_data;

  assign accept     = (state_q == S_IDLE) && epoch_i;
  assign scan_add   = (state_q == S_SCAN);
  assign scan_close = scan_add && (comp_q == LAST_COMP);
  assign upd_wr     = (state_q == S_UPD);
  assign busy_o     = (state_q != S_IDLE);

  assign rd_a_addr = upd_wr ? addr_of(s_new_q, a_next_q, comp_q)
                            : addr_of(s_new_q, scan_a_q, comp_q);
  assign rd_b_addr = addr_of(s_old_q, act_o, comp_q);
  assign wr_data   = sarsa_step(rd_b_data, rd_a_data, rwd_q[comp_q],
                                qval_t'(ALPHA), qval_t'(GAMMA));

  sarsa_qstore #(.DEPTH(DEPTH), .ADR_W(ADR_W)) u_store (
    .clk_i, .rst_ni,
    .rd_a_addr, .rd_a_data,
    .rd_b_addr, .rd_b_data,
    .wr_en(upd_wr), .wr_addr(rd_b_addr), .wr_data
  );

  sarsa_explore #(.N_OPT(N_OPT), .ACT_W(ACT_W), .WARMUP(WARMUP),
                  .EPS_HI(EPS_HI), .EPS_LO(EPS_LO)) u_explore (
    .clk_i, .rst_ni,
    .step_i(accept), .rand_i,
    .explore_o(expl_now), .pick_o(pick_now)
  );

  sarsa_argmax #(.N_OPT(N_OPT), .ACT_W(ACT_W), .SUM_W(SUM_W)) u_argmax (
    .clk_i, .rst_ni,
    .clr_i(accept), .add_i(scan_add), .val_i(rd_a_data),
    .close_i(scan_close), .cand_i(scan_a_q), .best_o(best)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      s_old_q  <= '0;
      s_new_q  <= '0;
      a_next_q <= '0;
      scan_a_q <= '0;
      pick_q   <= '0;
      comp_q   <= '0;
      expl_q   <= 1'b0;
      act_o    <= '0;
      done_o   <= 1'b0;
      for (int i = 0; i < N_COMP; i++) rwd_q[i] <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          for (int i = 0; i < N_COMP; i++) rwd_q[i] <= reward_i[i*16 +: 16];
          s_new_q  <= act_o;
          expl_q   <= expl_now;
          pick_q   <= pick_now;
          scan_a_q <= '0;
          comp_q   <= '0;
          state_q  <= S_SCAN;
        end
        S_SCAN: begin
          if (scan_close) begin
            comp_q <= '0;
            if (scan_a_q == LAST_OPT) state_q <= S_PICK;
            else scan_a_q <= scan_a_q + 1'b1;
          end else begin
            comp_q <= comp_q + 1'b1;
          end
        end
        S_PICK: begin
          a_next_q <= expl_q ? pick_q : best;
          comp_q   <= '0;
          state_q  <= S_UPD;
        end
        S_UPD: begin
          if (comp_q == LAST_COMP) state_q <= S_DONE;
          else comp_q <= comp_q + 1'b1;
        end
        S_DONE: begin
          act_o   <= a_next_q;
          s_old_q <= s_new_q;
          done_o  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // write counter per epoch, for the checker below
  logic [WC_W-1:0] wr_cnt_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni || accept) wr_cnt_q <= '0;
    else if (upd_wr)       wr_cnt_q <= wr_cnt_q + 1'b1;
  end

  // R1: output code always legal
  a_r1_act_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(act_o) < N_OPT);
  // R9: code moves only with the done pulse
  a_r9_act_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(act_o));
  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8: busy only ends with completion
  a_r8_busy_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R5: exactly one write per reward component per epoch
  a_r5_one_write_each: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (32'(wr_cnt_q) == N_COMP));

endmodule

// File: tb/sarsa_tune_agent_test.sv
module sarsa_tune_agent_test;

  localparam int N_OPT  = 3;
  localparam int N_COMP = 2;
  localparam int WARMUP = 3;
  localparam int EPS_HI = 32768;
  localparam int EPS_LO = 66;
  localparam int ALPHA  = 26;
  localparam int GAMMA  = 230;
  localparam int BUSY_LEN = N_OPT * N_COMP + N_COMP + 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        epoch_i = 1'b0;
  logic [31:0] reward_i = '0;
  logic [31:0] rand_i = '0;
  logic [1:0]  act_o;
  logic        busy_o, done_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  int mq [N_OPT][N_OPT][N_COMP];
  int m_s = 0, m_a = 0, m_step = 0;

  always #4 clk_i = ~clk_i;

  sarsa_tune_agent #(.N_OPT(N_OPT), .N_COMP(N_COMP), .WARMUP(WARMUP)) uut (
    .clk_i, .rst_ni, .epoch_i, .reward_i, .rand_i, .act_o, .busy_o, .done_o
  );

  function automatic int clampq(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int qmul(int a, int b);
    int p;
    p = a * b;
    if (p >= 0) return clampq(p / 256);
    return clampq(-((-p + 255) / 256));
  endfunction

  function automatic int learn(int qo, int qn, int r);
    int t, e;
    t = clampq(r + qmul(GAMMA, qn));
    e = clampq(t - qo);
    return clampq(qo + qmul(ALPHA, e));
  endfunction

  function automatic int model_epoch(int r0, int r1, logic [31:0] rnd);
    int thr, nxt, bs, sm;
    int rr [N_COMP];
    rr[0] = r0; rr[1] = r1;
    thr = (m_step < WARMUP) ? EPS_HI : EPS_LO;
    if (int'(rnd[15:0]) < thr) begin
      nxt = int'(rnd[31:16]) % N_OPT;
    end else begin
      nxt = 0;
      bs = mq[m_a][0][0] + mq[m_a][0][1];
      for (int a = 1; a < N_OPT; a++) begin
        sm = mq[m_a][a][0] + mq[m_a][a][1];
        if (sm > bs) begin bs = sm; nxt = a; end
      end
    end
    for (int c = 0; c < N_COMP; c++)
      mq[m_s][m_a][c] = learn(mq[m_s][m_a][c], mq[m_a][nxt][c], rr[c]);
    m_s = m_a;
    m_a = nxt;
    m_step++;
    return nxt;
  endfunction

  task automatic check(bit ok, string req, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic run_epoch(int r0, int r1, logic [31:0] rnd, bit poke, string req);
    int exp, prev, nbusy;
    bit seen, hold_ok;
    prev = m_a;
    exp = model_epoch(r0, r1, rnd);
    @(negedge clk_i);
    epoch_i  = 1'b1;
    reward_i = {16'(r1), 16'(r0)};
    rand_i   = rnd;
    nbusy = 0; seen = 0; hold_ok = 1;
    for (int k = 0; k < 60 && !seen; k++) begin
      @(negedge clk_i);
      epoch_i = 1'b0;
      if (poke && k == 3) begin
        epoch_i  = 1'b1;
        rand_i   = 32'h0001_0000;
        reward_i = {16'h8000, 16'h7fff};
      end
      if (done_o) seen = 1;
      else if (busy_o) begin
        nbusy++;
        if (int'(act_o) != prev) hold_ok = 0;
      end
    end
    check(seen, "R8 completion", int'(seen), 1);
    check(int'(act_o) == exp, req, int'(act_o), exp);
    check(nbusy == BUSY_LEN, "R8 busy length", nbusy, BUSY_LEN);
    check(hold_ok, "R9 code held while busy", int'(hold_ok), 1);
    @(negedge clk_i);
    check(!done_o, "R9 done width", int'(done_o), 0);
  endtask

  task automatic t_reset;
    check(act_o == 2'd0, "R1 act_o", int'(act_o), 0);
    check(!busy_o, "R1 busy_o", int'(busy_o), 0);
    check(!done_o, "R1 done_o", int'(done_o), 0);
  endtask

  task automatic t_tie;
    run_epoch(256, -128, 32'h0000_ffff, 0, "R2 tie to lowest");
  endtask

  task automatic t_explore;
    run_epoch(64, 64, 32'h0005_0000, 0, "R3 random pick mod");
  endtask

  task automatic t_warmup;
    run_epoch(-300, 10, 32'h0007_0064, 0, "R4 warm explore");
    run_epoch(128, 128, 32'h0007_0064, 0, "R4 low eps greedy");
    run_epoch(-50, 500, 32'h0004_0032, 0, "R4 low eps explore");
  endtask

  task automatic t_learning;
    run_epoch(1024, -256, 32'h0000_ffff, 0, "R5 R6 greedy");
    run_epoch(-2048, 300, 32'h0000_ffff, 0, "R5 R6 greedy");
    run_epoch(700, 700, 32'h0002_0000, 0, "R5 R6 explore");
    run_epoch(-900, -900, 32'h0000_ffff, 0, "R5 R6 greedy");
    run_epoch(40, -4000, 32'h0000_ffff, 0, "R5 R6 greedy");
    run_epoch(3000, 10, 32'h0001_0000, 0, "R5 R6 explore");
    run_epoch(0, 0, 32'h0000_ffff, 0, "R5 R6 greedy");
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 10; i++)
      run_epoch(32767, 32767, 32'h0000_ffff, 0, "R7 positive clamp");
    for (int i = 0; i < 6; i++)
      run_epoch(-32768, -32768, 32'h0000_ffff, 0, "R7 negative clamp");
    run_epoch(-32768, 32767, 32'h0002_0000, 0, "R7 mixed clamp");
    run_epoch(100, 100, 32'h0000_ffff, 0, "R7 after clamp");
  endtask

  task automatic t_busy_ignore;
    run_epoch(-600, 200, 32'h0000_ffff, 1, "R8 strobe ignored");
    @(negedge clk_i);
    check(!busy_o, "R8 no pending epoch", int'(busy_o), 0);
    run_epoch(50, -50, 32'h0000_ffff, 0, "R8 next epoch clean");
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < N_OPT; s++)
      for (int a = 0; a < N_OPT; a++)
        for (int c = 0; c < N_COMP; c++) mq[s][a][c] = 0;
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_tie();
    t_explore();
    t_warmup();
    t_learning();
    t_saturate();
    t_busy_ignore();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule